// File: doc/BRIEF.md
# Debug Port Read Command Sequencer

This block carries out the read-type commands of a debug port. A host-side byte front end hands it one opcode, with the target address alongside. The sequencer decodes the opcode and makes one aligned read on the internal memory bus, or two longword reads on a 64-bit trace line port. It then pushes the response bytes out one per cycle, most significant first. When requested it puts a status byte in front of the data. When handshaking is enabled it raises a one-cycle acknowledge just before the data.

The address and size of the last memory read are kept, so a repeat-read opcode can fetch the same location again without sending the address. Any internal read that hangs is abandoned after a parameterised number of cycles. In that case the data bytes come back as zero and a flag is set in the status byte. Opcodes are sampled only while the sequencer is idle. The host waits for the response of one command before it sends the next. `ack_en` is held steady for the whole of a command.

The controller has six states. IDLE waits for an opcode. MEM_WAIT holds a bus read. TB_WAIT holds a trace read. ACK gives the acknowledge pulse. SEND shifts out the response bytes. GAP is the fixed pause between trace longwords.

The transitions are as follows:
- IDLE goes to MEM_WAIT on a memory or repeat opcode, and to TB_WAIT on the trace opcode.
- MEM_WAIT and TB_WAIT go to ACK when the read completes with `ack_en` high. They go to SEND when it completes with `ack_en` low, or when it times out.
- ACK goes to SEND.
- SEND goes to IDLE after the last byte. After the first longword of a trace read it goes to TB_WAIT if `ack_en` is high, or to GAP if it is low.
- GAP goes to TB_WAIT once it has lasted GAP_CYC cycles.

Top module: `dbgrd_seq`

## Requirements
- R1: `mem_addr` is the command address with bit 0 cleared for a word read (size 01), bits 1:0 cleared for a longword read (size 10), and unchanged for a byte read (size 00). `mem_size` carries the size code.
- R2: A byte read returns the lane `mem_rdata[8k+7:8k]`, where k is the address bits 1:0. A word read returns `mem_rdata[16h+15:16h]`, where h is address bit 1, high byte first. A longword read returns bytes 31:24, 23:16, 15:8 and 7:0, in that order.
- R3: Memory read opcodes are 0x30+s (no status) and 0x38+s (with status), where s is the size code. Response bytes leave on consecutive cycles with `rsp_valid` high. After reset no byte, acknowledge or request is driven.
- R4: A with-status command sends one status byte before the data. That byte is captured when the read finishes. Bit 0 is 1 when the read timed out, and all other bits are 0.
- R5: With `ack_en` high, a completed read produces exactly one `ack_pulse` cycle, in the cycle just before the first response byte. With `ack_en` low, no pulse is produced.
- R6: Opcode 0x07 returns 8 bytes. The first longword is trace line bits 31:0 (`tb_half`=0). The second is bits 63:32 (`tb_half`=1). Each longword is sent most significant byte first.
- R7: For opcode 0x07 with `ack_en` high, each longword is preceded by its own acknowledge pulse. Each longword has its own timeout.
- R8: For opcode 0x07 with `ack_en` low, `tb_req` for the second longword rises no sooner than GAP_CYC+1 cycles after the cycle of the first longword's last byte.
- R9: When HAS_TRACE is 0, opcode 0x07 returns eight 0x00 bytes and never raises `tb_req`.
- R10: Opcode 0x54 (no status) and 0x55 (with status) re-read the address and size of the last memory read opcode. Repeat, trace and unknown opcodes leave that stored address and size unchanged.
- R11: A read not acknowledged within TMO_CYC cycles produces no acknowledge pulse. Its data bytes are 0x00, and any status byte is 0x01.
- R12: An opcode outside those listed produces no bus request, no acknowledge and no response byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Opcode present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | AW | Target address for memory read opcodes |
| ack_en | input | 1 | Acknowledge handshaking enabled |
| rsp_valid | output | 1 | A response byte is present |
| rsp_byte | output | 8 | Response byte |
| ack_pulse | output | 1 | One-cycle acknowledge before the data |
| mem_req | output | 1 | Memory read request, held until ack or timeout |
| mem_addr | output | AW | Aligned read address |
| mem_size | output | 2 | Read size code |
| mem_ack | input | 1 | Memory read complete |
| mem_rdata | input | 32 | Memory read data, four byte lanes |
| tb_req | output | 1 | Trace line read request |
| tb_half | output | 1 | Trace longword select, 0 = bits 31:0 |
| tb_ack | input | 1 | Trace read complete |
| tb_rdata | input | 32 | Selected trace longword |

## Verification
When `mem_ack` or `tb_ack` is sampled at an edge, the acknowledge pulse appears in the next cycle and the first byte in the cycle after that. Without handshaking, the first byte appears in the cycle right after the sampling edge. On a timeout, the first byte follows the TMO_CYC-th wait cycle. The bench samples outputs on the falling edge and logs acknowledges and bytes as one ordered token stream, stamped with cycle numbers. Each scenario therefore compares the exact order, and for the trace gap it compares the distance between the last byte of the first longword and the next `tb_req` rise. The bench waits a fixed 60 cycles per command, which covers the longest path: the trace gap, or the timeout with the test's TMO_CYC.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;

    localparam logic [7:0] OP_RD_MEM     = 8'h30;
    localparam logic [7:0] OP_RD_SAME    = 8'h54;
    localparam logic [7:0] OP_RD_TRACE   = 8'h07;
    localparam logic [7:0] MEM_OP_MASK   = 8'hF4;
    localparam logic [7:0] SAME_OP_MASK  = 8'hFE;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_WAIT,
        ST_TB_WAIT,
        ST_ACK,
        ST_SEND,
        ST_GAP
    } state_e;

    function automatic logic [2:0] size_bytes(size_e s);
        unique case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_WORD: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbgrd_align.sv
module dbgrd_align
    import dbgrd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  size_e         size_i,
    output logic [AW-1:0] addr_o
);
    always_comb begin
        unique case (size_i)
            SZ_WORD: addr_o = {addr_i[AW-1:1], 1'b0};
            SZ_LONG: addr_o = {addr_i[AW-1:2], 2'b00};
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dbgrd_lane.sv
module dbgrd_lane
    import dbgrd_pkg::*;
(
    input  logic [1:0]  lo_i,
    input  size_e       size_i,
    input  logic [31:0] rdata_i,
    output logic [31:0] val_o
);
    always_comb begin
        unique case (size_i)
            SZ_BYTE: val_o = {rdata_i[{lo_i, 3'b000} +: 8], 24'h0};
            SZ_WORD: val_o = {rdata_i[{lo_i[1], 4'b0000} +: 16], 16'h0};
            default: val_o = rdata_i;
        endcase
    end
endmodule

// File: rtl/dbgrd_timer.sv
module dbgrd_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dbgrd_seq.sv
module dbgrd_seq
    import dbgrd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int TMO_CYC   = 64,
    parameter int GAP_CYC   = 16,
    parameter bit HAS_TRACE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          ack_en,
    output logic          rsp_valid,
    output logic [7:0]    rsp_byte,
    output logic          ack_pulse,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tb_req,
    output logic          tb_half,
    input  logic          tb_ack,
    input  logic [31:0]   tb_rdata
);
    localparam int SRW = 40;

    state_e        state, nxt;
    logic [AW-1:0] cur_addr, last_addr;
    size_e         cur_sz, last_sz;
    logic          ws_q, trc_q, half_q;
    logic [SRW-1:0] sr;
    logic [2:0]    nleft;

    logic          is_mem_op, is_same_op, is_trace_op, op_ws;
    logic          tmo_exp, gap_exp, tb_hit;
    logic [31:0]   lane_val, mem_val, tb_val;
    logic [2:0]    mem_cnt;

    always_comb begin
        is_mem_op   = ((cmd_op & MEM_OP_MASK) == OP_RD_MEM) && (cmd_op[1:0] != 2'b11);
        is_same_op  = (cmd_op & SAME_OP_MASK) == OP_RD_SAME;
        is_trace_op = cmd_op == OP_RD_TRACE;
        op_ws       = is_mem_op ? cmd_op[3] : cmd_op[0];
    end

    dbgrd_align #(.AW(AW)) align_i (
        .addr_i (cur_addr),
        .size_i (cur_sz),
        .addr_o (mem_addr)
    );

    dbgrd_lane lane_i (
        .lo_i    (cur_addr[1:0]),
        .size_i  (cur_sz),
        .rdata_i (mem_rdata),
        .val_o   (lane_val)
    );

    dbgrd_timer #(.LIMIT(TMO_CYC)) tmo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     ((state == ST_MEM_WAIT) || (state == ST_TB_WAIT)),
        .expired (tmo_exp)
    );

    dbgrd_timer #(.LIMIT(GAP_CYC)) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_GAP),
        .expired (gap_exp)
    );

    assign tb_hit  = !HAS_TRACE || tb_ack;
    assign tb_val  = (HAS_TRACE && tb_ack) ? tb_rdata : 32'h0;
    assign mem_val = mem_ack ? lane_val : 32'h0;
    assign mem_cnt = size_bytes(cur_sz) + {2'b00, ws_q};

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (is_mem_op || is_same_op) nxt = ST_MEM_WAIT;
                    else if (is_trace_op)        nxt = ST_TB_WAIT;
                end
            end
            ST_MEM_WAIT: begin
                if (mem_ack)      nxt = ack_en ? ST_ACK : ST_SEND;
                else if (tmo_exp) nxt = ST_SEND;
            end
            ST_TB_WAIT: begin
                if (tb_hit)       nxt = ack_en ? ST_ACK : ST_SEND;
                else if (tmo_exp) nxt = ST_SEND;
            end
            ST_ACK: nxt = ST_SEND;
            ST_SEND: begin
                if (nleft == 3'd1)
                    nxt = (trc_q && !half_q) ? (ack_en ? ST_TB_WAIT : ST_GAP) : ST_IDLE;
            end
            ST_GAP: if (gap_exp) nxt = ST_TB_WAIT;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            cur_sz    <= SZ_BYTE;
            last_addr <= '0;
            last_sz   <= SZ_BYTE;
            ws_q      <= 1'b0;
            trc_q     <= 1'b0;
            half_q    <= 1'b0;
            sr        <= '0;
            nleft     <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        ws_q   <= op_ws;
                        trc_q  <= is_trace_op;
                        half_q <= 1'b0;
                        if (is_mem_op) begin
                            cur_addr  <= cmd_addr;
                            cur_sz    <= size_e'(cmd_op[1:0]);
                            last_addr <= cmd_addr;
                            last_sz   <= size_e'(cmd_op[1:0]);
                        end else if (is_same_op) begin
                            cur_addr <= last_addr;
                            cur_sz   <= last_sz;
                        end
                    end
                end
                ST_MEM_WAIT: begin
                    if (mem_ack || tmo_exp) begin
                        sr    <= ws_q ? {7'b0, !mem_ack, mem_val} : {mem_val, 8'h00};
                        nleft <= mem_cnt;
                    end
                end
                ST_TB_WAIT: begin
                    if (tb_hit || tmo_exp) begin
                        sr    <= {tb_val, 8'h00};
                        nleft <= 3'd4;
                    end
                end
                ST_SEND: begin
                    sr    <= sr << 8;
                    nleft <= nleft - 1'b1;
                    if (nleft == 3'd1 && trc_q) half_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rsp_valid = state == ST_SEND;
        rsp_byte  = sr[SRW-1 -: 8];
        ack_pulse = state == ST_ACK;
        mem_req   = state == ST_MEM_WAIT;
        mem_size  = cur_sz;
        tb_req    = HAS_TRACE && (state == ST_TB_WAIT);
        tb_half   = half_q;
    end
endmodule

// File: rtl/dbgrd_seq_chk.sv
module dbgrd_seq_chk #(
    parameter int AW      = 16,
    parameter int GAP_CYC = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_en,
    input logic          rsp_valid,
    input logic          ack_pulse,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic          tb_req,
    input logic          tb_half
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] since_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           since_byte <= '0;
        else if (rsp_valid)                   since_byte <= '0;
        else if (since_byte != GW'(GAP_CYC))  since_byte <= since_byte + 1'b1;
    end

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'b01) |-> !mem_addr[0]);                 // R1
    AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'b10) |-> (mem_addr[1:0] == 2'b00));     // R1
    AST_ACK_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |=> rsp_valid);                                         // R5
    AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> ack_en);                                            // R5
    AST_ACK_NOT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_pulse && rsp_valid));                                       // R5
    AST_ONE_PORT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tb_req));                                            // R6
    AST_TRACE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tb_req) && tb_half && !ack_en) |-> (since_byte == GW'(GAP_CYC))); // R8
endmodule

bind dbgrd_seq dbgrd_seq_chk #(.AW(AW), .GAP_CYC(GAP_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_en    (ack_en),
    .rsp_valid (rsp_valid),
    .ack_pulse (ack_pulse),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .tb_req    (tb_req),
    .tb_half   (tb_half)
);

// File: tb/dbgrd_seq_tb.sv
module dbgrd_seq_tb_top;
    localparam int AW  = 16;
    localparam int TMO = 20;
    localparam int GAP = 16;
    localparam int LAT = 3;
    localparam logic [63:0] TLINE = 64'h8877_6655_4433_2211;
    localparam logic [8:0]  ACKT  = 9'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = 8'h00;
    logic [AW-1:0] cmd_addr = '0;
    logic          ack_en = 1'b0;
    logic          mem_en = 1'b1;

    logic          rsp_valid, ack_pulse, mem_req, tb_req, tb_half;
    logic [7:0]    rsp_byte;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic          mem_ack = 1'b0, tb_ack = 1'b0;
    logic [31:0]   mem_rdata = '0, tb_rdata = '0;

    logic          n_rsp_valid, n_ack_pulse, n_mem_req, n_tb_req, n_tb_half;
    logic [7:0]    n_rsp_byte;
    logic [AW-1:0] n_mem_addr;
    logic [1:0]    n_mem_size;

    dbgrd_seq #(.AW(AW), .TMO_CYC(TMO), .GAP_CYC(GAP), .HAS_TRACE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .ack_en(ack_en), .rsp_valid(rsp_valid),
        .rsp_byte(rsp_byte), .ack_pulse(ack_pulse), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tb_req(tb_req), .tb_half(tb_half),
        .tb_ack(tb_ack), .tb_rdata(tb_rdata));

    dbgrd_seq #(.AW(AW), .TMO_CYC(TMO), .GAP_CYC(GAP), .HAS_TRACE(1'b0)) dut_nt_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .ack_en(ack_en), .rsp_valid(n_rsp_valid),
        .rsp_byte(n_rsp_byte), .ack_pulse(n_ack_pulse), .mem_req(n_mem_req),
        .mem_addr(n_mem_addr), .mem_size(n_mem_size), .mem_ack(n_mem_req),
        .mem_rdata(32'h0), .tb_req(n_tb_req), .tb_half(n_tb_half),
        .tb_ack(1'b0), .tb_rdata(32'h0));

    function automatic logic [7:0] lane(logic [AW-1:0] a, int k);
        return a[9:2] ^ 8'(8'h11 * (k + 1));
    endfunction

    // memory and trace responders
    int mlat = 0, tlat = 0;
    always @(posedge clk) begin
        if (mem_req && !mem_ack && mem_en) begin
            if (mlat == LAT - 1) begin
                mem_ack   <= 1'b1;
                mem_rdata <= {lane(mem_addr, 3), lane(mem_addr, 2), lane(mem_addr, 1), lane(mem_addr, 0)};
                mlat      <= 0;
            end else mlat <= mlat + 1;
        end else begin
            mem_ack <= 1'b0;
            mlat    <= 0;
        end
        if (tb_req && !tb_ack) begin
            if (tlat == LAT - 1) begin
                tb_ack   <= 1'b1;
                tb_rdata <= tb_half ? TLINE[63:32] : TLINE[31:0];
                tlat     <= 0;
            end else tlat <= tlat + 1;
        end else begin
            tb_ack <= 1'b0;
            tlat   <= 0;
        end
    end

    // monitor
    logic [8:0] tq[$];
    logic [8:0] nq[$];
    logic [8:0] eq[$];
    int bcyc[$];
    int rise[$];
    int cyc = 0, mreq_cnt = 0, n_tbreq_cnt = 0;
    logic [AW-1:0] seen_addr = '0;
    logic tb_prev = 1'b0;
    int nvec = 0, nfail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ack_pulse) tq.push_back(ACKT);
        if (rsp_valid) begin
            tq.push_back({1'b0, rsp_byte});
            bcyc.push_back(cyc);
        end
        if (n_ack_pulse) nq.push_back(ACKT);
        if (n_rsp_valid) nq.push_back({1'b0, n_rsp_byte});
        if (mem_req) begin
            mreq_cnt++;
            seen_addr = mem_addr;
        end
        if (n_tb_req) n_tbreq_cnt++;
        if (tb_req && !tb_prev) rise.push_back(cyc);
        tb_prev = tb_req;
    end

    always @(posedge clk) begin
        if (cyc > 60000) begin
            nfail++;
            $display("FAIL watchdog: run hung, act cycle %0d exp < 60000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    function automatic string qstr(input logic [8:0] q[$]);
        string s = "";
        foreach (q[i]) s = {s, (q[i] == ACKT) ? " ACK" : $sformatf(" %02h", q[i][7:0])};
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic check_stream(input string req, input logic [8:0] got[$]);
        bit ok = (got.size() == eq.size());
        if (ok) foreach (eq[i]) if (got[i] != eq[i]) ok = 1'b0;
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: act [%s ] exp [%s ]", req, qstr(got), qstr(eq));
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [AW-1:0] a);
        tq.delete(); nq.delete(); bcyc.delete(); rise.delete();
        mreq_cnt = 0; n_tbreq_cnt = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic t_reset;
        check(!rsp_valid && !ack_pulse && !mem_req && !tb_req, "R3 reset",
              {rsp_valid, ack_pulse, mem_req, tb_req}, 0);
    endtask

    task automatic t_byte_lanes;
        ack_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] a = AW'(16'h0120 + k);
            run_cmd(8'h30, a);
            eq = '{{1'b0, lane(a, k)}};
            check_stream($sformatf("R2 byte lane %0d", k), tq);
        end
        check(seen_addr == 16'h0123, "R1 byte addr untouched", seen_addr, 16'h0123);
    endtask

    task automatic t_word_long;
        ack_en = 1'b0;
        run_cmd(8'h31, 16'h0123);
        eq = '{{1'b0, lane(16'h0123, 3)}, {1'b0, lane(16'h0123, 2)}};
        check_stream("R2 word upper half", tq);
        check(seen_addr == 16'h0122, "R1 word align", seen_addr, 16'h0122);
        run_cmd(8'h31, 16'h0240);
        eq = '{{1'b0, lane(16'h0240, 1)}, {1'b0, lane(16'h0240, 0)}};
        check_stream("R2 word lower half", tq);
        run_cmd(8'h32, 16'h0347);
        eq = '{{1'b0, lane(16'h0344, 3)}, {1'b0, lane(16'h0344, 2)},
               {1'b0, lane(16'h0344, 1)}, {1'b0, lane(16'h0344, 0)}};
        check_stream("R3 long read", tq);
        check(seen_addr == 16'h0344, "R1 long align", seen_addr, 16'h0344);
    endtask

    task automatic t_status_ack;
        ack_en = 1'b1;
        run_cmd(8'h39, 16'h0456);
        eq = '{ACKT, 9'h000, {1'b0, lane(16'h0456, 3)}, {1'b0, lane(16'h0456, 2)}};
        check_stream("R4 R5 status word with ack", tq);
        ack_en = 1'b0;
    endtask

    task automatic t_trace;
        ack_en = 1'b1;
        run_cmd(8'h07, '0);
        eq = '{ACKT, 9'h044, 9'h033, 9'h022, 9'h011, ACKT, 9'h088, 9'h077, 9'h066, 9'h055};
        check_stream("R6 R7 trace with ack", tq);
        eq = '{ACKT, 9'h0, 9'h0, 9'h0, 9'h0, ACKT, 9'h0, 9'h0, 9'h0, 9'h0};
        check_stream("R9 no trace buffer", nq);
        check(n_tbreq_cnt == 0, "R9 no trace request", n_tbreq_cnt, 0);
        ack_en = 1'b0;
        run_cmd(8'h07, '0);
        eq = '{9'h044, 9'h033, 9'h022, 9'h011, 9'h088, 9'h077, 9'h066, 9'h055};
        check_stream("R6 trace no ack", tq);
        if (rise.size() == 2 && bcyc.size() == 8)
            check(rise[1] - bcyc[3] >= GAP + 1, "R8 trace gap", rise[1] - bcyc[3], GAP + 1);
        else
            check(1'b0, "R8 trace gap events", rise.size(), 2);
    endtask

    task automatic t_repeat_unknown;
        ack_en = 1'b0;
        run_cmd(8'h31, 16'h0512);
        run_cmd(8'h07, '0);
        ack_en = 1'b1;
        run_cmd(8'h55, 16'h0FFF);
        eq = '{ACKT, 9'h000, {1'b0, lane(16'h0512, 3)}, {1'b0, lane(16'h0512, 2)}};
        check_stream("R10 repeat after trace", tq);
        run_cmd(8'h99, 16'h0700);
        eq = '{};
        check_stream("R12 unknown opcode silent", tq);
        check(mreq_cnt == 0, "R12 unknown opcode no request", mreq_cnt, 0);
        ack_en = 1'b0;
        run_cmd(8'h54, 16'h0000);
        eq = '{{1'b0, lane(16'h0512, 3)}, {1'b0, lane(16'h0512, 2)}};
        check_stream("R10 R12 repeat after unknown", tq);
    endtask

    task automatic t_timeout;
        ack_en = 1'b1;
        mem_en = 1'b0;
        run_cmd(8'h3A, 16'h0600);
        eq = '{9'h001, 9'h0, 9'h0, 9'h0, 9'h0};
        check_stream("R11 R4 timeout status", tq);
        mem_en = 1'b1;
        ack_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_byte_lanes();
        t_word_long();
        t_status_ack();
        t_trace();
        t_repeat_unknown();
        t_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule